// File: doc/BRIEF.md
# Debug Break Timing and Saved-PC Selection

This block sits beside an in-order instruction pipeline. It decides on which instruction boundary a debug break is taken and which program counter value the break exception must push. An external comparator reports a break match, tagged with its kind, on `match_valid`. The kind is one of three: an instruction match that breaks before the matched instruction, an instruction match that breaks after it, or a data-access match from the CPU or the DMA master. The pipeline reports each instruction boundary with the address of the instruction about to run and whether interrupts are accepted there. It also reports each completed instruction with its address.

The break is raised only at a boundary where interrupts are accepted. The saved PC is always the address of the instruction in front of which the break actually lands, and that instruction is marked as not to be executed. A break that would fall on a masked boundary is carried to the next accepting boundary. Only one break is outstanding at a time.

Top module: `brk_pc_select`

## Requirements
- R1: A synchronous active-high `rst` clears any outstanding break, drives `brk_req_o` and `suppress_o` low and `saved_pc_o` to zero. After reset, an accepting boundary with no match raises no break.
- R2: `brk_req_o` is high for exactly the clock after a cycle in which a break is taken at a boundary with `bnd_valid=1` and `bnd_int_ok=1`. On that same edge `saved_pc_o` takes that boundary's `bnd_addr`, and it holds its value while no break is raised.
- R3: A before-execution match (`match_kind`=0) records `match_addr`. From the next cycle on, a boundary whose `bnd_addr` equals it takes the break if interrupts are accepted there, and `saved_pc_o` equals the matched address.
- R4: A break that becomes due at a boundary with `bnd_int_ok=0` is deferred across any number of masked boundaries. It is taken at the next accepting boundary, and `saved_pc_o` is that boundary's address.
- R5: An after-execution match (`match_kind`=1) records `match_addr`. The break becomes due when `done_valid` reports that address complete, and it is taken at the first accepting boundary in that cycle or later. The saved PC is the address of the following instruction.
- R6: A data-access match (`match_kind`=2) is due at once and is taken at the first accepting boundary, including one in the same cycle. `saved_pc_o` is the address of the instruction about to start there.
- R7: While a break is outstanding, a further instruction match (kind 0 or 1) is discarded. A data-access match promotes a recorded instruction match to due immediately.
- R8: `suppress_o` pulses in the same cycle as `brk_req_o`, marking the instruction at `saved_pc_o` as not executed. It is low in every other cycle.
- R9: A match with reserved kind 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| match_valid | input | 1 | Break match pulse from the comparator |
| match_kind | input | 2 | 0 before-exec, 1 after-exec, 2 data access, 3 reserved |
| match_addr | input | AW | Fetch address of the matched instruction |
| bnd_valid | input | 1 | Instruction boundary this cycle |
| bnd_addr | input | AW | Address of the instruction about to execute |
| bnd_int_ok | input | 1 | Interrupts accepted at this boundary |
| done_valid | input | 1 | An instruction finished executing |
| done_addr | input | AW | Address of the finished instruction |
| brk_req_o | output | 1 | One-cycle break request |
| suppress_o | output | 1 | Instruction at the saved PC is not executed |
| saved_pc_o | output | AW | PC value to push for the break exception |

## Verification
A wrong arming state shows up as a missing, early or extra `brk_req_o` one clock after the boundary where the break should have been decided. A wrong recorded address shows up as a break at the wrong boundary or as a `saved_pc_o` that does not match that boundary. The reference model predicts all three outputs every cycle, so any divergence is reported at the first edge where it reaches a port. Runs of back-to-back masked boundaries and merged matches are the sequences most likely to expose a stale pending state.

// File: rtl/bpsel_pkg.sv
package bpsel_pkg;
  typedef enum logic [1:0] {
    MK_PRE  = 2'd0,
    MK_POST = 2'd1,
    MK_DATA = 2'd2,
    MK_RSVD = 2'd3
  } match_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WPRE  = 2'd1,
    ST_WPOST = 2'd2,
    ST_DUE   = 2'd3
  } arm_state_e;
endpackage

// File: rtl/bpsel_watch.sv
module bpsel_watch #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [AW-1:0] cap_addr,
  input  logic          bnd_valid,
  input  logic [AW-1:0] bnd_addr,
  input  logic          done_valid,
  input  logic [AW-1:0] done_addr,
  output logic          pre_hit,
  output logic          post_hit
);
  logic [AW-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst)          tag_q <= '0;
    else if (capture) tag_q <= cap_addr;
  end

  // the recorded instruction reaches its boundary / finishes executing
  always_comb begin
    pre_hit  = bnd_valid  && (bnd_addr  == tag_q);
    post_hit = done_valid && (done_addr == tag_q);
  end
endmodule

// File: rtl/bpsel_ctrl.sv
module bpsel_ctrl
  import bpsel_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       match_valid,
  input  logic [1:0] match_kind,
  input  logic       pre_hit,
  input  logic       post_hit,
  input  logic       bnd_valid,
  input  logic       bnd_int_ok,
  output logic       capture,
  output logic       take
);
  arm_state_e st_q, st_d;
  logic data_now, inst_now, due;

  always_comb begin
    data_now = match_valid && (match_kind == MK_DATA);
    inst_now = match_valid && ((match_kind == MK_PRE) || (match_kind == MK_POST));
    due      = (st_q == ST_DUE) || data_now
             || ((st_q == ST_WPRE)  && pre_hit)
             || ((st_q == ST_WPOST) && post_hit);
    take     = due && bnd_valid && bnd_int_ok;
    capture  = (st_q == ST_IDLE) && inst_now && !due;

    st_d = st_q;
    if (take)         st_d = ST_IDLE;
    else if (due)     st_d = ST_DUE;
    else if (capture) st_d = (match_kind == MK_PRE) ? ST_WPRE : ST_WPOST;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/bpsel_outreg.sv
module bpsel_outreg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [AW-1:0] bnd_addr,
  output logic          brk_req_o,
  output logic          suppress_o,
  output logic [AW-1:0] saved_pc_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      brk_req_o  <= 1'b0;
      suppress_o <= 1'b0;
      saved_pc_o <= '0;
    end else begin
      brk_req_o  <= take;
      suppress_o <= take;
      if (take) saved_pc_o <= bnd_addr;
    end
  end
endmodule

// File: rtl/brk_pc_select.sv
module brk_pc_select #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          match_valid,
  input  logic [1:0]    match_kind,
  input  logic [AW-1:0] match_addr,
  input  logic          bnd_valid,
  input  logic [AW-1:0] bnd_addr,
  input  logic          bnd_int_ok,
  input  logic          done_valid,
  input  logic [AW-1:0] done_addr,
  output logic          brk_req_o,
  output logic          suppress_o,
  output logic [AW-1:0] saved_pc_o
);
  logic capture, take, pre_hit, post_hit;

  bpsel_watch #(.AW(AW)) u_watch (
    .clk(clk), .rst(rst), .capture(capture), .cap_addr(match_addr),
    .bnd_valid(bnd_valid), .bnd_addr(bnd_addr),
    .done_valid(done_valid), .done_addr(done_addr),
    .pre_hit(pre_hit), .post_hit(post_hit)
  );

  bpsel_ctrl u_ctrl (
    .clk(clk), .rst(rst), .match_valid(match_valid), .match_kind(match_kind),
    .pre_hit(pre_hit), .post_hit(post_hit),
    .bnd_valid(bnd_valid), .bnd_int_ok(bnd_int_ok),
    .capture(capture), .take(take)
  );

  bpsel_outreg #(.AW(AW)) u_out (
    .clk(clk), .rst(rst), .take(take), .bnd_addr(bnd_addr),
    .brk_req_o(brk_req_o), .suppress_o(suppress_o), .saved_pc_o(saved_pc_o)
  );
endmodule

// File: rtl/brk_pc_select_chk.sv
module brk_pc_select_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          match_valid,
  input logic [1:0]    match_kind,
  input logic          bnd_valid,
  input logic [AW-1:0] bnd_addr,
  input logic          bnd_int_ok,
  input logic          brk_req_o,
  input logic          suppress_o,
  input logic [AW-1:0] saved_pc_o
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!brk_req_o && !suppress_o));

  assert_req_at_boundary_R2: assert property (@(posedge clk) disable iff (rst)
    brk_req_o |-> $past(bnd_valid && bnd_int_ok));

  assert_saved_pc_R2: assert property (@(posedge clk) disable iff (rst)
    brk_req_o |-> (saved_pc_o == $past(bnd_addr)));

  assert_pc_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!brk_req_o && !$past(rst)) |-> $stable(saved_pc_o));

  assert_data_same_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    (match_valid && match_kind == 2'd2 && bnd_valid && bnd_int_ok) |=> brk_req_o);

  assert_suppress_pair_R8: assert property (@(posedge clk) disable iff (rst)
    suppress_o |-> brk_req_o);
endmodule

bind brk_pc_select brk_pc_select_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .match_valid(match_valid), .match_kind(match_kind),
  .bnd_valid(bnd_valid), .bnd_addr(bnd_addr), .bnd_int_ok(bnd_int_ok),
  .brk_req_o(brk_req_o), .suppress_o(suppress_o), .saved_pc_o(saved_pc_o)
);

// File: tb/brk_pc_select_tb.sv
`timescale 1ns/1ps
module brk_pc_select_tb;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic match_valid = 1'b0;
  logic [1:0] match_kind = 2'd0;
  logic [AW-1:0] match_addr = '0;
  logic bnd_valid = 1'b0;
  logic [AW-1:0] bnd_addr = '0;
  logic bnd_int_ok = 1'b0;
  logic done_valid = 1'b0;
  logic [AW-1:0] done_addr = '0;
  logic brk_req_o, suppress_o;
  logic [AW-1:0] saved_pc_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int breaks_seen = 0;
  string cur_r = "R1";

  always #2 clk = ~clk;  // 250 MHz

  brk_pc_select #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .match_valid(match_valid), .match_kind(match_kind),
    .match_addr(match_addr), .bnd_valid(bnd_valid), .bnd_addr(bnd_addr),
    .bnd_int_ok(bnd_int_ok), .done_valid(done_valid), .done_addr(done_addr),
    .brk_req_o(brk_req_o), .suppress_o(suppress_o), .saved_pc_o(saved_pc_o)
  );

  // behavioural reference: 0 nothing, 1 waiting for boundary, 2 waiting for completion, 3 due
  int mode = 0;
  logic [AW-1:0] tag = '0;
  logic exp_req = 1'b0;
  logic exp_sup = 1'b0;
  logic [AW-1:0] exp_pc = '0;

  always @(posedge clk) begin
    bit ready;
    if (rst) begin
      mode = 0; tag = '0; exp_req = 0; exp_sup = 0; exp_pc = '0;
    end else begin
      ready = (mode == 3) || (match_valid && match_kind == 2)
           || (mode == 1 && bnd_valid && bnd_addr == tag)
           || (mode == 2 && done_valid && done_addr == tag);
      exp_req = 0; exp_sup = 0;
      if (ready && bnd_valid && bnd_int_ok) begin
        exp_req = 1; exp_sup = 1; exp_pc = bnd_addr; mode = 0;
      end else if (ready) begin
        mode = 3;
      end else if (mode == 0 && match_valid && match_kind < 2) begin
        mode = int'(match_kind) + 1; tag = match_addr;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    cycles++;
    checks++;
    if (brk_req_o !== exp_req || suppress_o !== exp_sup || saved_pc_o !== exp_pc) begin
      errors++;
      $display("FAIL %s t=%0t req/sup/pc actual %b/%b/%h expected %b/%b/%h",
               cur_r, $time, brk_req_o, suppress_o, saved_pc_o, exp_req, exp_sup, exp_pc);
    end
    if (brk_req_o === 1'b1) breaks_seen++;
  end

  task automatic step(input bit mv, input int kd, input int ma,
                      input bit bv, input int ba, input bit ok,
                      input bit dv, input int da);
    @(negedge clk);
    match_valid = mv; match_kind = kd[1:0]; match_addr = ma;
    bnd_valid = bv; bnd_addr = ba; bnd_int_ok = ok;
    done_valid = dv; done_addr = da;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic expect_breaks(input int n, input string r);
    checks++;
    if (breaks_seen != n) begin
      errors++;
      $display("FAIL %s break count actual %0d expected %0d", r, breaks_seen, n);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: nothing outstanding after reset
    cur_r = "R1";
    step(0, 0, 0, 1, 'h40, 1, 0, 0);
    idle(2);
    expect_breaks(0, "R1");

    // R3: break in front of the matched instruction
    cur_r = "R3";
    step(1, 0, 'h100, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 'h0FC, 1, 1, 'h0F8);
    step(0, 0, 0, 1, 'h100, 1, 1, 'h0FC);
    idle(2);
    expect_breaks(1, "R3");

    // R4: matched boundary masked, then back-to-back masked boundaries
    cur_r = "R4";
    step(1, 0, 'h200, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 'h200, 0, 0, 0);
    step(0, 0, 0, 1, 'h204, 0, 1, 'h200);
    step(0, 0, 0, 1, 'h208, 0, 1, 'h204);
    idle(1);
    step(0, 0, 0, 1, 'h20C, 1, 1, 'h208);
    idle(2);
    expect_breaks(2, "R4");

    // R5: after-execution match, boundary of matched instr is not a break point
    cur_r = "R5";
    step(1, 1, 'h300, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 'h300, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 'h300);
    step(0, 0, 0, 1, 'h304, 1, 0, 0);
    idle(1);
    // completion and next boundary in one cycle, next boundary masked once
    step(1, 1, 'h340, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 'h344, 0, 1, 'h340);
    step(0, 0, 0, 1, 'h348, 1, 1, 'h344);
    idle(2);
    expect_breaks(4, "R5");

    // R6: data-access match, later and same-cycle boundary
    cur_r = "R6";
    step(1, 2, 'hABC, 0, 0, 0, 1, 'h40C);
    step(0, 0, 0, 1, 'h410, 1, 0, 0);
    idle(1);
    step(1, 2, 0, 1, 'h420, 1, 0, 0);
    idle(1);
    step(1, 2, 0, 1, 'h430, 0, 0, 0);
    step(0, 0, 0, 1, 'h434, 0, 0, 0);
    step(0, 0, 0, 1, 'h438, 1, 0, 0);
    idle(2);
    expect_breaks(7, "R6");

    // R7: merging while outstanding
    cur_r = "R7";
    step(1, 0, 'h500, 0, 0, 0, 0, 0);
    step(1, 0, 'h600, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 'h600, 1, 0, 0);
    step(0, 0, 0, 1, 'h500, 1, 0, 0);
    idle(1);
    step(1, 1, 'h700, 0, 0, 0, 0, 0);
    step(1, 2, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 'h6F0, 1, 0, 0);
    idle(2);
    expect_breaks(9, "R7");

    // R9: reserved kind ignored
    cur_r = "R9";
    step(1, 3, 'h800, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 'h800, 1, 1, 'h800);
    step(0, 0, 0, 1, 'h804, 1, 0, 0);
    idle(2);
    expect_breaks(9, "R9");

    // R8 and R2: random streams over a small address space
    cur_r = "R8";
    for (int i = 0; i < 4000; i++) begin
      step($urandom_range(0, 3) == 0, $urandom_range(0, 3), $urandom_range(0, 7) * 4,
           $urandom_range(0, 1), $urandom_range(0, 7) * 4, $urandom_range(0, 2) != 0,
           $urandom_range(0, 1), $urandom_range(0, 7) * 4);
      if (i == 2000) cur_r = "R2";
    end
    idle(3);
    finish_run();
  end
endmodule